// File: doc/BRIEF.md
# Data Address Watchpoint

This block sits beside a processor's load/store pipeline and flags accesses that touch a software-programmed window of memory. Software programs two control registers: a base register that holds the doubleword-aligned start of the window, and a control register that holds the window length in doublewords, separate enables for loads and stores, one enable per privilege level, and a real-mode match-control bit. The real-mode bit is kept but has no effect on matching.

Each cycle the pipeline may present one access with its effective address, a load/store flag, a size code and the current privilege level. One cycle later the block raises `hit` when the access overlaps the window and the access type and privilege level are enabled. The pipeline uses `hit` to stop the access before it commits. A write to either control register replaces the earlier setting at once. Reset clears both registers, so the watchpoint starts disabled.

Top module: `dwatch_unit`

## Requirements
- R1: The base register keeps address bits 63..3 of the written value and stores zero in bits 2..0. The read-back on `base_rd` always has its low three bits clear.
- R2: The window covers bytes base through base + (N+1)*8 - 1, where N is control bits [5:0]. An access of 2^S bytes (S = `req_size`: 0 for 1 byte, 1 for 2, 2 for 4, 3 for 8) matches when any of its bytes lies inside the window. The bounds are inclusive.
- R3: A load (`req_is_write`=0) can match only when control bit 6 is set. A store can match only when control bit 7 is set.
- R4: When control bits 6 and 7 are both clear, no access matches.
- R5: Privilege level 0 (user) is enabled by control bit 8, level 1 (supervisor) by bit 9 and level 2 (hypervisor) by bit 10. Only the enable bit of the access's own level counts. Level 3 never matches.
- R6: When control bits 8, 9 and 10 are all clear, no access matches.
- R7: `hit` is registered. It is high in the cycle after a valid request that matches, and it is low after any cycle with `req_valid` low.
- R8: A control register write is applied at the next clock edge. A request in the following cycle is judged only against the new settings, and nothing of the earlier setting remains.
- R9: Control bit 11 (real-mode match control) is stored and read back on `ext_rd`. `unimpl` is high exactly while the bit is set. The bit does not change `hit`.
- R10: After reset, `base_rd`, `ext_rd`, `hit` and `unimpl` are all zero.
- R11: Address arithmetic does not wrap. A window or access that runs past the top of the 64-bit space does not match low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_we | input | 1 | Write strobe for the base register |
| cfg_base_data | input | 64 | Value written to the base register |
| cfg_ext_we | input | 1 | Write strobe for the control register |
| cfg_ext_data | input | 12 | Value written to the control register |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 64 | Effective address of the access |
| req_is_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | Log2 of the access size in bytes |
| req_priv | input | 2 | Privilege level of the access |
| base_rd | output | 64 | Read-back of the base register |
| ext_rd | output | 12 | Read-back of the control register |
| hit | output | 1 | Registered match for the previous cycle's access |
| unimpl | output | 1 | The real-mode match-control bit is set |

## Verification
The hardest cases to reach are accesses whose first or last byte lands exactly on a window edge, and windows near the top of the address space. Uniform random addresses almost never produce either. The bench therefore places the base at chosen values, including the highest aligned doubleword. The random phase draws addresses from a band a few bytes either side of the current window and regularly rewrites the control register, so that boundary straddles, every type and privilege combination, and back-to-back reconfiguration all occur often.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;

  localparam int ADDR_W  = 64;
  localparam int CNT_W   = 6;
  localparam int SIZE_W  = 2;
  localparam int PRIV_W  = 2;
  localparam int N_PRIV  = 3;
  localparam int DW_LSB  = 3;

  // control register layout, bit 11 down to bit 0
  typedef struct packed {
    logic             rm_ctl;
    logic             prv_hyp;
    logic             prv_sup;
    logic             prv_user;
    logic             st_en;
    logic             ld_en;
    logic [CNT_W-1:0] dw_cnt;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  typedef enum logic [PRIV_W-1:0] {
    LVL_USER = 2'd0,
    LVL_SUP  = 2'd1,
    LVL_HYP  = 2'd2,
    LVL_RSVD = 2'd3
  } lvl_e;

endpackage

// File: rtl/dwatch_cfg_regs.sv
module dwatch_cfg_regs
  import dwatch_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int ALIGN = DW_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [AW-1:0] base_q,
  output ctl_t          ctl_q
);

  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << ALIGN) - 64'd1);

  logic [AW-1:0] base_d;
  ctl_t          ctl_d;

  always_comb begin
    base_d = base_q;
    if (base_we) begin
      base_d = base_wdata & ~LOW_MASK;
    end
  end

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d = ctl_t'(ctl_wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_we) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

endmodule

// File: rtl/dwatch_range_cmp.sv
module dwatch_range_cmp
  import dwatch_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int CW    = CNT_W,
  parameter int SW    = SIZE_W,
  parameter int ALIGN = DW_LSB
) (
  input  logic [AW-1:0] win_base,
  input  logic [CW-1:0] win_cnt,
  input  logic [AW-1:0] acc_addr,
  input  logic [SW-1:0] acc_size,
  output logic          overlap
);

  // one guard bit so that no end address wraps past the top
  localparam int EW = AW + 1;

  logic [EW-1:0] win_span;
  logic [EW-1:0] acc_span;
  logic [EW-1:0] win_lo;
  logic [EW-1:0] win_hi;
  logic [EW-1:0] acc_lo;
  logic [EW-1:0] acc_hi;

  always_comb begin
    win_span = (EW'(win_cnt) + EW'(1)) << ALIGN;
    acc_span = EW'(1) << acc_size;
    win_lo   = EW'(win_base);
    acc_lo   = EW'(acc_addr);
    win_hi   = win_lo + win_span - EW'(1);
    acc_hi   = acc_lo + acc_span - EW'(1);
    overlap  = (acc_lo <= win_hi) && (win_lo <= acc_hi);
  end

endmodule

// File: rtl/dwatch_qual.sv
module dwatch_qual
  import dwatch_pkg::*;
(
  input  ctl_t              ctl,
  input  logic              is_write,
  input  logic [PRIV_W-1:0] priv,
  output logic              qual_ok
);

  logic [N_PRIV-1:0] lvl_en;
  logic [N_PRIV-1:0] lvl_sel;
  logic              type_ok;
  logic              priv_ok;

  assign lvl_en = {ctl.prv_hyp, ctl.prv_sup, ctl.prv_user};

  for (genvar g = 0; g < N_PRIV; g++) begin : g_lvl
    assign lvl_sel[g] = lvl_en[g] && (priv == PRIV_W'(g));
  end

  always_comb begin
    type_ok = is_write ? ctl.st_en : ctl.ld_en;
    priv_ok = |lvl_sel;
    qual_ok = type_ok && priv_ok;
  end

endmodule

// File: rtl/dwatch_unit.sv
module dwatch_unit
  import dwatch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_base_we,
  input  logic [ADDR_W-1:0] cfg_base_data,
  input  logic              cfg_ext_we,
  input  logic [CTL_W-1:0]  cfg_ext_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_is_write,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [PRIV_W-1:0] req_priv,
  output logic [ADDR_W-1:0] base_rd,
  output logic [CTL_W-1:0]  ext_rd,
  output logic              hit,
  output logic              unimpl
);

  logic [ADDR_W-1:0] base_q;
  ctl_t              ctl_q;
  logic              overlap;
  logic              qual_ok;
  logic              hit_d;
  logic              hit_q;

  dwatch_cfg_regs #(.AW(ADDR_W), .ALIGN(DW_LSB)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .base_we    (cfg_base_we),
    .base_wdata (cfg_base_data),
    .ctl_we     (cfg_ext_we),
    .ctl_wdata  (cfg_ext_data),
    .base_q     (base_q),
    .ctl_q      (ctl_q)
  );

  dwatch_range_cmp #(.AW(ADDR_W), .CW(CNT_W), .SW(SIZE_W), .ALIGN(DW_LSB)) u_cmp (
    .win_base (base_q),
    .win_cnt  (ctl_q.dw_cnt),
    .acc_addr (req_addr),
    .acc_size (req_size),
    .overlap  (overlap)
  );

  dwatch_qual u_qual (
    .ctl      (ctl_q),
    .is_write (req_is_write),
    .priv     (req_priv),
    .qual_ok  (qual_ok)
  );

  always_comb begin
    hit_d = req_valid && qual_ok && overlap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit_d;
    end
  end

  assign hit     = hit_q;
  assign base_rd = base_q;
  assign ext_rd  = ctl_q;
  assign unimpl  = ctl_q.rm_ctl;

endmodule

// File: rtl/dwatch_checker.sv
module dwatch_checker
  import dwatch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_base_we,
  input logic              cfg_ext_we,
  input logic              req_valid,
  input logic              req_is_write,
  input logic [PRIV_W-1:0] req_priv,
  input logic [ADDR_W-1:0] base_rd,
  input logic [CTL_W-1:0]  ext_rd,
  input logic              hit,
  input logic              unimpl
);

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    base_rd[2:0] == 3'b000); // R1

  AST_HIT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !hit); // R7

  AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_is_write && !ext_rd[6]) |=> !hit); // R3

  AST_STORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_write && !ext_rd[7]) |=> !hit); // R3

  AST_TYPE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd[7:6] == 2'b00) |=> !hit); // R4

  AST_PRIV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd[10:8] == 3'b000) |=> !hit); // R6

  AST_RSVD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_priv == 2'd3) |=> !hit); // R5

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_base_we |=> $stable(base_rd)); // R8

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ext_we |=> $stable(ext_rd)); // R8

  AST_UNIMPL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unimpl) |-> $past(cfg_ext_we)); // R9

endmodule

bind dwatch_unit dwatch_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_base_we  (cfg_base_we),
  .cfg_ext_we   (cfg_ext_we),
  .req_valid    (req_valid),
  .req_is_write (req_is_write),
  .req_priv     (req_priv),
  .base_rd      (base_rd),
  .ext_rd       (ext_rd),
  .hit          (hit),
  .unimpl       (unimpl)
);

// File: tb/tb_dwatch_unit.sv
`timescale 1ns/1ps
module tb_dwatch_unit;

  logic        clk;
  logic        rst_n;
  logic        cfg_base_we;
  logic [63:0] cfg_base_data;
  logic        cfg_ext_we;
  logic [11:0] cfg_ext_data;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        req_is_write;
  logic [1:0]  req_size;
  logic [1:0]  req_priv;
  logic [63:0] base_rd;
  logic [11:0] ext_rd;
  logic        hit;
  logic        unimpl;

  int n_checks = 0;
  int n_errors = 0;
  logic [63:0] m_base;
  logic [11:0] m_ext;

  dwatch_unit dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(5.0 * 200000);
    n_errors++;
    $display("FAIL watchdog expired: got=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic bit model_hit(logic [63:0] b, logic [11:0] e, logic [63:0] a,
                                   bit w, logic [1:0] sz, logic [1:0] p);
    logic [64:0] wlo, whi, alo, ahi;
    bit tok, pok;
    wlo = {1'b0, b};
    whi = wlo + ((65'(e[5:0]) + 65'd1) * 65'd8) - 65'd1;
    alo = {1'b0, a};
    ahi = alo + (65'd1 << sz) - 65'd1;
    tok = w ? e[7] : e[6];
    case (p)
      2'd0: pok = e[8];
      2'd1: pok = e[9];
      2'd2: pok = e[10];
      default: pok = 1'b0;
    endcase
    return tok && pok && (alo <= whi) && (wlo <= ahi);
  endfunction

  task automatic wr_base(logic [63:0] v);
    cfg_base_we = 1'b1; cfg_base_data = v;
    @(negedge clk);
    cfg_base_we = 1'b0;
    m_base = v & ~64'h7;
  endtask

  task automatic wr_ext(logic [11:0] v);
    cfg_ext_we = 1'b1; cfg_ext_data = v;
    @(negedge clk);
    cfg_ext_we = 1'b0;
    m_ext = v;
  endtask

  task automatic access(string tag, logic [63:0] a, bit w, logic [1:0] sz, logic [1:0] p);
    req_valid = 1'b1; req_addr = a; req_is_write = w; req_size = sz; req_priv = p;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, 64'(hit), 64'(model_hit(m_base, m_ext, a, w, sz, p)));
  endtask

  // enables: load bit6, store bit7, user bit8, sup bit9, hyp bit10
  localparam logic [11:0] EN_ALL = 12'h7C0;

  initial begin
    rst_n = 1'b0; cfg_base_we = 0; cfg_base_data = '0; cfg_ext_we = 0;
    cfg_ext_data = '0; req_valid = 0; req_addr = '0; req_is_write = 0;
    req_size = '0; req_priv = '0; m_base = '0; m_ext = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 base", base_rd, 64'd0);
    check("R10 ext", 64'(ext_rd), 64'd0);
    check("R10 hit", 64'(hit), 64'd0);
    check("R10 unimpl", 64'(unimpl), 64'd0);
    access("R10 disabled after reset", 64'h0, 1'b0, 2'd3, 2'd0);

    // R1 alignment
    wr_base(64'h0000_0000_0000_1007);
    check("R1 base aligned", base_rd, 64'h1000);

    // R2 window of 16 bytes [0x1000, 0x100F]
    wr_ext(EN_ALL | 12'd1);
    access("R2 below window", 64'hFF8, 1'b0, 2'd3, 2'd0);
    access("R2 straddle low edge", 64'hFF9, 1'b0, 2'd3, 2'd0);
    check("R2 straddle hit", 64'(hit), 64'd1);
    access("R2 last byte", 64'h100F, 1'b1, 2'd0, 2'd1);
    access("R2 first byte after", 64'h1010, 1'b1, 2'd0, 2'd1);
    check("R2 after window", 64'(hit), 64'd0);

    // R3 type gating
    wr_ext(12'h740 | 12'd1);
    access("R3 load enabled", 64'h1004, 1'b0, 2'd2, 2'd2);
    access("R3 store disabled", 64'h1004, 1'b1, 2'd2, 2'd2);
    wr_ext(12'h780 | 12'd1);
    access("R3 load disabled", 64'h1004, 1'b0, 2'd2, 2'd2);
    access("R3 store enabled", 64'h1004, 1'b1, 2'd2, 2'd2);

    // R4 both type enables clear
    wr_ext(12'h700 | 12'd1);
    access("R4 off load", 64'h1000, 1'b0, 2'd3, 2'd0);
    access("R4 off store", 64'h1000, 1'b1, 2'd3, 2'd1);

    // R5 privilege selection
    wr_ext(12'h2C0 | 12'd1);
    access("R5 sup enabled", 64'h1000, 1'b0, 2'd0, 2'd1);
    access("R5 user disabled", 64'h1000, 1'b0, 2'd0, 2'd0);
    access("R5 hyp disabled", 64'h1000, 1'b0, 2'd0, 2'd2);
    wr_ext(12'h7C0 | 12'd1);
    access("R5 level3 never", 64'h1000, 1'b0, 2'd0, 2'd3);

    // R6 all privilege enables clear
    wr_ext(12'h0C0 | 12'd1);
    access("R6 priv off", 64'h1000, 1'b1, 2'd3, 2'd2);

    // R7 no hit without valid
    wr_ext(EN_ALL | 12'd1);
    req_addr = 64'h1000; req_priv = 2'd0; req_valid = 1'b0;
    @(negedge clk);
    check("R7 idle no hit", 64'(hit), 64'd0);

    // R8 re-arm: move window, old window no longer matches
    wr_base(64'h2000);
    access("R8 old window gone", 64'h1000, 1'b0, 2'd3, 2'd0);
    check("R8 old no hit", 64'(hit), 64'd0);
    access("R8 new window", 64'h2008, 1'b0, 2'd3, 2'd0);
    check("R8 new hit", 64'(hit), 64'd1);

    // R9 real-mode control bit stored, flagged, no effect
    wr_ext(12'h800 | EN_ALL | 12'd1);
    check("R9 readback", 64'(ext_rd), 64'hFC1);
    check("R9 unimpl set", 64'(unimpl), 64'd1);
    access("R9 no effect hit", 64'h2008, 1'b0, 2'd3, 2'd0);
    access("R9 no effect miss", 64'h2010, 1'b0, 2'd0, 2'd0);
    wr_ext(EN_ALL | 12'd1);
    check("R9 unimpl clear", 64'(unimpl), 64'd0);

    // R11 window at top of space, no wrap to low addresses
    wr_base(64'hFFFF_FFFF_FFFF_FFFF);
    wr_ext(EN_ALL | 12'd63);
    check("R11 base top", base_rd, 64'hFFFF_FFFF_FFFF_FFF8);
    access("R11 top byte", 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd0, 2'd0);
    access("R11 no wrap", 64'h0, 1'b0, 2'd3, 2'd0);
    check("R11 low miss", 64'(hit), 64'd0);
    wr_base(64'h8);
    access("R11 access past top", 64'hFFFF_FFFF_FFFF_FFFC, 1'b0, 2'd3, 2'd0);

    // random phase (R2 R3 R5 R8 R9)
    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) begin
        wr_base({$urandom(), $urandom()});
        wr_ext(12'($urandom()));
        check("R1 random base", 64'(base_rd[2:0]), 64'd0);
      end else if (i % 17 == 0) begin
        wr_ext(12'($urandom()) | EN_ALL);
      end
      begin
        logic [63:0] off;
        off = 64'($urandom_range(0, (32'(m_ext[5:0]) + 1) * 8 + 32)) - 64'd16;
        access("R2 random", m_base + off, 1'($urandom()), 2'($urandom()), 2'($urandom()));
      end
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule